// File: doc/BRIEF.md
# Fixed-Pattern 8x8 Intra Predictor

This block generates 8x8 intra-predicted pixel blocks for a video encoder without any mode search. The caller gives the position of the macroblock (whether it sits in the first macroblock column and whether it is the top-left macroblock of the frame), the 8x8 sub-block index inside a 16x16 luma macroblock (0 upper-left, 1 upper-right, 2 lower-left, 3 lower-right, processed in that order) and whether the block is luma or chroma. The prediction mode follows from these inputs alone. The block then streams the 64 predicted pixels in raster order over a valid/ready handshake, and reports the mode it used with each pixel.

Reference pixels come back from the reconstruction path as one 8-bit value per cycle, each tagged with its row and column inside the sub-block that was predicted last. Only the right-most column and the bottom row of each finished block are kept, in seven fixed 8-byte slots. Upper luma sub-blocks are predicted horizontally from their left neighbour. The block therefore never needs the reconstructed line above the macroblock, and its storage does not depend on the frame width. A new request is accepted only after the reconstruction of the previous block has completed, so every prediction uses final reference pixels.

Top module: `fixpat_intra_gen`

## Requirements
- R1: After reset, `req_ready` is 1, `pred_valid` is 0 and every stored reference pixel reads as 0.
- R2: A block requested with `req_frame_tl`=1 (luma sub-block 0 or chroma) uses DC mode: `pred_mode`=0 and all 64 pixels equal 128.
- R3: Luma sub-block 1 uses horizontal mode (`pred_mode`=1), with row r equal to row r of column 7 of sub-block 0. Luma sub-block 0 outside the first column and off the frame top-left also uses horizontal mode, from column 7 of the previous macroblock's sub-block 1.
- R4: Luma sub-blocks 2 and 3 use vertical mode (`pred_mode`=2), with column c equal to column c of row 7 of sub-block 0 or 1 of the same macroblock, respectively.
- R5: Luma sub-block 0 with `req_first_col`=1 and `req_frame_tl`=0 uses vertical mode from row 7 of the most recent sub-block 2 that was reconstructed in the first column.
- R6: A chroma block off the first column uses horizontal mode from column 7 of the previous chroma block. A chroma block in the first column, away from the frame top-left, uses vertical mode from row 7 of the most recent first-column chroma block.
- R7: Beat k of a block carries row k/8, column k%8. A block has exactly 64 beats, and `pred_last` is 1 on the 64th beat only.
- R8: While `pred_valid`=1 and `pred_ready`=0, `pred_pix`, `pred_mode` and `pred_last` hold their values.
- R9: `req_ready` falls on acceptance and stays 0 until all 64 beats have been sent and a reconstructed pixel tagged row 7, column 7 has been received. It rises on the cycle after both hold.
- R10: Reconstructed pixels at positions other than column 7 or row 7 have no effect on any later prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Prediction request present |
| req_ready | output | 1 | Request can be accepted |
| req_first_col | input | 1 | Macroblock is in the first column |
| req_frame_tl | input | 1 | Macroblock is the frame top-left one |
| req_sub | input | 2 | Luma sub-block index 0..3 |
| req_chroma | input | 1 | 1 for a chroma block |
| recon_valid | input | 1 | Reconstructed pixel present |
| recon_row | input | 3 | Row of the reconstructed pixel |
| recon_col | input | 3 | Column of the reconstructed pixel |
| recon_pix | input | 8 | Reconstructed pixel value |
| pred_valid | output | 1 | Predicted pixel present |
| pred_ready | input | 1 | Consumer takes the pixel |
| pred_pix | output | 8 | Predicted pixel |
| pred_mode | output | 3 | 0 DC, 1 horizontal, 2 vertical |
| pred_last | output | 1 | Last pixel of the block |

## Verification
A walk over three macroblock positions is used: the frame top-left, an interior macroblock, and a first-column macroblock one row down, with luma and chroma blocks interleaved. Each reconstructed block carries a distinct seeded pattern, so an output row or column identifies both the slot it was read from and the edge (column 7 or row 7) it was captured from. Interior reconstructed values differ from edge values, which exposes any capture of non-edge pixels. Directed runs cover stalls of the output stream, a partial reconstruction that must keep the request side closed, and a reset in the middle of a block that must clear the stored references.

// File: rtl/fpi_pkg.sv
// Shared types for the fixed-pattern intra predictor.
// Assumes: a single encoding of prediction modes shared by all sub-modules.
package fpi_pkg;

    // Prediction mode, encoded as it appears on the mode output.
    typedef enum logic [2:0] {
        MODE_DC  = 3'd0,
        MODE_HOR = 3'd1,
        MODE_VER = 3'd2
    } mode_e;

    // Reference slot identifiers: each slot holds one 8-pixel edge.
    typedef enum logic [2:0] {
        SRC_LCOL_A = 3'd0,  // column 7 of luma sub-block 0
        SRC_LCOL_B = 3'd1,  // column 7 of luma sub-block 1
        SRC_ROW_A  = 3'd2,  // row 7 of luma sub-block 0
        SRC_ROW_B  = 3'd3,  // row 7 of luma sub-block 1
        SRC_FCOL   = 3'd4,  // row 7 of first-column luma sub-block 2
        SRC_CLEFT  = 3'd5,  // column 7 of last chroma block
        SRC_CCOL   = 3'd6   // row 7 of first-column chroma block
    } src_e;

    localparam int NUM_SLOTS = 7;

endpackage

// File: rtl/fpi_mode_sel.sv
// Fixed-pattern mode selector.
// Derives the prediction mode and the reference slot from the block position
// only; no cost is evaluated. Purely combinational.
// Assumes: sub-blocks are indexed 0 UL, 1 UR, 2 LL, 3 LR.
module fpi_mode_sel
    import fpi_pkg::*;
(
    input  logic       first_col,
    input  logic       frame_tl,
    input  logic [1:0] sub,
    input  logic       chroma,
    output mode_e      mode,
    output src_e       src
);

    // Pattern lookup: position -> mode and reference slot.
    always_comb begin
        mode = MODE_HOR;
        src  = SRC_CLEFT;
        if (chroma) begin
            if (frame_tl) begin
                mode = MODE_DC;
                src  = SRC_CCOL;
            end else if (first_col) begin
                mode = MODE_VER;
                src  = SRC_CCOL;
            end else begin
                mode = MODE_HOR;
                src  = SRC_CLEFT;
            end
        end else begin
            case (sub)
                2'd0: begin
                    if (frame_tl) begin
                        mode = MODE_DC;
                        src  = SRC_FCOL;
                    end else if (first_col) begin
                        mode = MODE_VER;
                        src  = SRC_FCOL;
                    end else begin
                        mode = MODE_HOR;
                        src  = SRC_LCOL_B;
                    end
                end
                2'd1: begin
                    mode = MODE_HOR;
                    src  = SRC_LCOL_A;
                end
                2'd2: begin
                    mode = MODE_VER;
                    src  = SRC_ROW_A;
                end
                default: begin
                    mode = MODE_VER;
                    src  = SRC_ROW_B;
                end
            endcase
        end
    end

endmodule

// File: rtl/fpi_ref_store.sv
// Constant-size reference store.
// Captures column 7 and row 7 of each reconstructed block into fixed slots,
// chosen by the context of the block being reconstructed, and presents one
// slot as a packed vector (element i at bits i*PIX_W).
// Assumes: BLK is a power of two; capture and read never target the same
// slot in the same cycle (enforced by the top-level request gating).
module fpi_ref_store
    import fpi_pkg::*;
#(
    parameter  int PIX_W = 8,
    parameter  int BLK   = 8,
    localparam int POS_W = $clog2(BLK)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_en,
    input  logic [POS_W-1:0]     cap_row,
    input  logic [POS_W-1:0]     cap_col,
    input  logic [PIX_W-1:0]     cap_pix,
    input  logic                 ctx_chroma,
    input  logic                 ctx_first_col,
    input  logic [1:0]           ctx_sub,
    input  src_e                 rd_src,
    output logic [BLK*PIX_W-1:0] rd_vec
);

    localparam logic [POS_W-1:0] EDGE = POS_W'(BLK - 1);

    logic [PIX_W-1:0] mem [NUM_SLOTS][BLK];
    logic             col_we;
    logic             row_we;
    src_e             col_slot;
    src_e             row_slot;

    // Decide which slot, if any, receives the right-most column pixel.
    always_comb begin
        col_we   = 1'b0;
        col_slot = SRC_CLEFT;
        if (cap_en && cap_col == EDGE) begin
            if (ctx_chroma) begin
                col_we   = 1'b1;
                col_slot = SRC_CLEFT;
            end else if (ctx_sub == 2'd0) begin
                col_we   = 1'b1;
                col_slot = SRC_LCOL_A;
            end else if (ctx_sub == 2'd1) begin
                col_we   = 1'b1;
                col_slot = SRC_LCOL_B;
            end
        end
    end

    // Decide which slot, if any, receives the bottom-row pixel.
    always_comb begin
        row_we   = 1'b0;
        row_slot = SRC_ROW_A;
        if (cap_en && cap_row == EDGE) begin
            if (ctx_chroma) begin
                row_we   = ctx_first_col;
                row_slot = SRC_CCOL;
            end else if (ctx_sub == 2'd0) begin
                row_we   = 1'b1;
                row_slot = SRC_ROW_A;
            end else if (ctx_sub == 2'd1) begin
                row_we   = 1'b1;
                row_slot = SRC_ROW_B;
            end else if (ctx_sub == 2'd2) begin
                row_we   = ctx_first_col;
                row_slot = SRC_FCOL;
            end
        end
    end

    // Slot storage: clear on reset, then write the edge pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                for (int i = 0; i < BLK; i++) begin
                    mem[s][i] <= '0;
                end
            end
        end else begin
            if (col_we) mem[int'(col_slot)][cap_row] <= cap_pix;
            if (row_we) mem[int'(row_slot)][cap_col] <= cap_pix;
        end
    end

    // Read port: pack the selected slot into one vector.
    always_comb begin
        for (int i = 0; i < BLK; i++) begin
            rd_vec[i*PIX_W +: PIX_W] = mem[int'(rd_src)][i];
        end
    end

endmodule

// File: rtl/fpi_pix_gen.sv
// Prediction pixel generator.
// On start, snapshots the mode and the 8-pixel reference edge, then emits
// BLK*BLK pixels in raster order on a valid/ready handshake.
// Assumes: start is only asserted while busy is low.
module fpi_pix_gen
    import fpi_pkg::*;
#(
    parameter  int PIX_W = 8,
    parameter  int BLK   = 8,
    localparam int POS_W = $clog2(BLK),
    localparam int IDX_W = 2 * POS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  mode_e                start_mode,
    input  logic [BLK*PIX_W-1:0] start_ref,
    output logic                 busy,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [PIX_W-1:0]     out_pix,
    output mode_e                out_mode,
    output logic                 out_last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK * BLK - 1);
    localparam logic [PIX_W-1:0] DC_VAL   = PIX_W'(1 << (PIX_W - 1));

    logic [IDX_W-1:0]     idx;
    logic [BLK*PIX_W-1:0] ref_q;
    mode_e                mode_q;
    logic [POS_W-1:0]     row;
    logic [POS_W-1:0]     col;

    // Block sequencer: load on start, step on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            idx    <= '0;
            mode_q <= MODE_DC;
            ref_q  <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            idx    <= '0;
            mode_q <= start_mode;
            ref_q  <= start_ref;
        end else if (busy && out_ready) begin
            if (idx == LAST_IDX) busy <= 1'b0;
            idx <= idx + 1'b1;
        end
    end

    assign row = idx[IDX_W-1:POS_W];
    assign col = idx[POS_W-1:0];

    // Pixel datapath: constant, row-indexed or column-indexed edge.
    always_comb begin
        case (mode_q)
            MODE_HOR: out_pix = ref_q[row*PIX_W +: PIX_W];
            MODE_VER: out_pix = ref_q[col*PIX_W +: PIX_W];
            default:  out_pix = DC_VAL;
        endcase
    end

    assign out_valid = busy;
    assign out_mode  = mode_q;
    assign out_last  = busy && (idx == LAST_IDX);

endmodule

// File: rtl/fixpat_intra_gen.sv
// Fixed-pattern intra predictor, top level.
// Accepts a position-tagged request, picks the mode from a fixed pattern,
// streams the predicted block, and captures edges of the reconstructed
// block into a constant-size store. A new request waits until the previous
// block is fully sent and its reconstruction has delivered pixel (last,last).
// Assumes: reconstructed pixels of a block arrive after its request and end
// with the bottom-right pixel; BLK is a power of two.
module fixpat_intra_gen
    import fpi_pkg::*;
#(
    parameter  int PIX_W = 8,
    parameter  int BLK   = 8,
    localparam int POS_W = $clog2(BLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_first_col,
    input  logic             req_frame_tl,
    input  logic [1:0]       req_sub,
    input  logic             req_chroma,
    input  logic             recon_valid,
    input  logic [POS_W-1:0] recon_row,
    input  logic [POS_W-1:0] recon_col,
    input  logic [PIX_W-1:0] recon_pix,
    output logic             pred_valid,
    input  logic             pred_ready,
    output logic [PIX_W-1:0] pred_pix,
    output logic [2:0]       pred_mode,
    output logic             pred_last
);

    localparam logic [POS_W-1:0] EDGE = POS_W'(BLK - 1);

    logic                 pending;
    logic                 busy;
    logic                 accept;
    logic                 recon_done;
    logic                 ctx_chroma;
    logic                 ctx_first_col;
    logic [1:0]           ctx_sub;
    mode_e                sel_mode;
    src_e                 sel_src;
    mode_e                gen_mode;
    logic [BLK*PIX_W-1:0] ref_vec;

    assign req_ready  = !busy && !pending;
    assign accept     = req_valid && req_ready;
    assign recon_done = recon_valid && pending &&
                        (recon_row == EDGE) && (recon_col == EDGE);

    // Request context and reconstruction-pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending       <= 1'b0;
            ctx_chroma    <= 1'b0;
            ctx_first_col <= 1'b0;
            ctx_sub       <= '0;
        end else if (accept) begin
            pending       <= 1'b1;
            ctx_chroma    <= req_chroma;
            ctx_first_col <= req_first_col;
            ctx_sub       <= req_sub;
        end else if (recon_done) begin
            pending       <= 1'b0;
        end
    end

    fpi_mode_sel u_sel (
        .first_col (req_first_col),
        .frame_tl  (req_frame_tl),
        .sub       (req_sub),
        .chroma    (req_chroma),
        .mode      (sel_mode),
        .src       (sel_src)
    );

    fpi_ref_store #(.PIX_W(PIX_W), .BLK(BLK)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .cap_en        (recon_valid && pending),
        .cap_row       (recon_row),
        .cap_col       (recon_col),
        .cap_pix       (recon_pix),
        .ctx_chroma    (ctx_chroma),
        .ctx_first_col (ctx_first_col),
        .ctx_sub       (ctx_sub),
        .rd_src        (sel_src),
        .rd_vec        (ref_vec)
    );

    fpi_pix_gen #(.PIX_W(PIX_W), .BLK(BLK)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_mode (sel_mode),
        .start_ref  (ref_vec),
        .busy       (busy),
        .out_valid  (pred_valid),
        .out_ready  (pred_ready),
        .out_pix    (pred_pix),
        .out_mode   (gen_mode),
        .out_last   (pred_last)
    );

    assign pred_mode = gen_mode;

endmodule

// File: rtl/fpi_checker.sv
// Protocol checker for the fixed-pattern intra predictor, bound to the top.
// Assumes: same parameters as the bound instance.
module fpi_checker #(
    parameter  int PIX_W = 8,
    parameter  int BLK   = 8,
    localparam int IDX_W = 2 * $clog2(BLK)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             pred_valid,
    input logic             pred_ready,
    input logic [PIX_W-1:0] pred_pix,
    input logic [2:0]       pred_mode,
    input logic             pred_last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK * BLK - 1);
    localparam logic [PIX_W-1:0] DC_VAL   = PIX_W'(1 << (PIX_W - 1));

    logic [IDX_W-1:0] beat_cnt;

    // Independent beat counter for the block length check.
    always_ff @(posedge clk) begin
        if (!rst_n) beat_cnt <= '0;
        else if (pred_valid && pred_ready) beat_cnt <= pred_last ? '0 : beat_cnt + 1'b1;
    end

    p_dc_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && pred_mode == 3'd0) |-> pred_pix == DC_VAL);

    p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> pred_mode <= 3'd2);

    p_block_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> (pred_last == (beat_cnt == LAST_IDX)));

    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && !pred_ready) |=>
        (pred_valid && $stable(pred_pix) && $stable(pred_mode) && $stable(pred_last)));

    p_mode_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && pred_ready && !pred_last) |=> $stable(pred_mode));

    p_busy_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> !req_ready);

    p_accept_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind fixpat_intra_gen fpi_checker #(.PIX_W(PIX_W), .BLK(BLK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .pred_valid (pred_valid),
    .pred_ready (pred_ready),
    .pred_pix   (pred_pix),
    .pred_mode  (pred_mode),
    .pred_last  (pred_last)
);

// File: tb/sim_fixpat_intra_gen.sv
module sim_fixpat_intra_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_first_col = 1'b0;
    logic       req_frame_tl = 1'b0;
    logic [1:0] req_sub = 2'd0;
    logic       req_chroma = 1'b0;
    logic       recon_valid = 1'b0;
    logic [2:0] recon_row = 3'd0;
    logic [2:0] recon_col = 3'd0;
    logic [7:0] recon_pix = 8'd0;
    logic       pred_valid;
    logic       pred_ready = 1'b0;
    logic [7:0] pred_pix;
    logic [2:0] pred_mode;
    logic       pred_last;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    fixpat_intra_gen u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_first_col(req_first_col), .req_frame_tl(req_frame_tl),
        .req_sub(req_sub), .req_chroma(req_chroma),
        .recon_valid(recon_valid), .recon_row(recon_row),
        .recon_col(recon_col), .recon_pix(recon_pix),
        .pred_valid(pred_valid), .pred_ready(pred_ready),
        .pred_pix(pred_pix), .pred_mode(pred_mode), .pred_last(pred_last)
    );

    // Vector: {first_col, frame_tl, sub[1:0], chroma, recon seed[7:0], mode[2:0], src seed[7:0]}
    localparam int NV = 13;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 1'b1, 2'd0, 1'b0, 8'd1,  3'd0, 8'd0},   // TL luma sub0: DC
        {1'b1, 1'b1, 2'd1, 1'b0, 8'd2,  3'd1, 8'd1},   // sub1: H from sub0
        {1'b1, 1'b1, 2'd2, 1'b0, 8'd3,  3'd2, 8'd1},   // sub2: V from sub0
        {1'b1, 1'b1, 2'd3, 1'b0, 8'd4,  3'd2, 8'd2},   // sub3: V from sub1
        {1'b1, 1'b1, 2'd0, 1'b1, 8'd5,  3'd0, 8'd0},   // TL chroma: DC
        {1'b0, 1'b0, 2'd0, 1'b0, 8'd6,  3'd1, 8'd2},   // next MB sub0: H from prev sub1
        {1'b0, 1'b0, 2'd1, 1'b0, 8'd7,  3'd1, 8'd6},
        {1'b0, 1'b0, 2'd2, 1'b0, 8'd8,  3'd2, 8'd6},
        {1'b0, 1'b0, 2'd3, 1'b0, 8'd9,  3'd2, 8'd7},
        {1'b0, 1'b0, 2'd0, 1'b1, 8'd10, 3'd1, 8'd5},   // chroma: H from prev chroma
        {1'b1, 1'b0, 2'd0, 1'b0, 8'd11, 3'd2, 8'd3},   // first col sub0: V from sub2 above
        {1'b1, 1'b0, 2'd0, 1'b1, 8'd12, 3'd2, 8'd5},   // first col chroma: V
        {1'b1, 1'b0, 2'd1, 1'b0, 8'd13, 3'd1, 8'd11}
    };

    // Reconstructed pixel pattern; edge and interior values differ by seed.
    function automatic logic [7:0] rpix(int s, int r, int c);
        return 8'((s * 29 + r * 8 + c * 3 + 5) & 255);
    endfunction

    // Expected predicted pixel; src < 0 means a cleared store (all zero).
    function automatic logic [7:0] epix(int m, int src, int r, int c);
        if (m == 0) return 8'd128;
        if (src < 0) return 8'd0;
        if (m == 1) return rpix(src, r, 7);
        return rpix(src, 7, c);
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic send_req(bit fc, bit tl, logic [1:0] sub, bit ch);
        @(negedge clk);
        req_first_col = fc; req_frame_tl = tl; req_sub = sub; req_chroma = ch;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Receive one block with pred_ready high; starts at the negedge after acceptance.
    task automatic recv_block(int m, int src, string tag);
        int bad_pix = 0, bad_last = 0, first_act = 0, first_exp = 0;
        pred_ready = 1'b1;
        for (int k = 0; k < 64; k++) begin
            if (k != 0) @(negedge clk);
            if (k == 0) check(pred_mode == 3'(m), tag, "mode", pred_mode, m);
            if (!pred_valid || pred_pix != epix(m, src, k / 8, k % 8)) begin
                if (bad_pix == 0) begin
                    first_act = pred_pix;
                    first_exp = epix(m, src, k / 8, k % 8);
                end
                bad_pix++;
            end
            if (pred_last != (k == 63)) bad_last++;
        end
        check(bad_pix == 0, {tag, "/R7"}, "raster pixels", first_act, first_exp);
        check(bad_last == 0, "R7", "last-beat mismatches", bad_last, 0);
        @(negedge clk);
        check(!pred_valid, "R7", "valid after 64 beats", pred_valid, 0);
    endtask

    task automatic send_recon(int seed, int upto);
        for (int k = 0; k <= upto; k++) begin
            @(negedge clk);
            recon_valid = 1'b1;
            recon_row = 3'(k / 8); recon_col = 3'(k % 8);
            recon_pix = rpix(seed, k / 8, k % 8);
        end
        @(negedge clk);
        recon_valid = 1'b0;
    endtask

    function automatic string tag_of(bit fc, logic [1:0] sub, bit ch, int m);
        if (m == 0) return "R2";
        if (ch) return "R6";
        if (m == 1) return "R3";
        if (fc && sub == 2'd0) return "R5";
        return "R4";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check(pred_valid == 1'b0, "R1", "pred_valid after reset", pred_valid, 0);

        // Table walk over three macroblock positions (R2..R7, R10)
        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            int m, src, seed;
            v = VEC[i];
            seed = int'(v[18:11]); m = int'(v[10:8]); src = int'(v[7:0]);
            send_req(v[23], v[22], v[21:20], v[19]);
            recv_block(m, src, tag_of(v[23], v[21:20], v[19], m));
            check(!req_ready, "R9", "ready before reconstruction", req_ready, 0);
            send_recon(seed, 63);
            check(req_ready, "R9", "ready after reconstruction", req_ready, 1);
        end

        // Stall: chroma off first column, H from last chroma (seed 12) (R8, R6)
        send_req(1'b0, 1'b0, 2'd0, 1'b1);
        pred_ready = 1'b0;
        begin
            logic [7:0] p0;
            p0 = pred_pix;
            repeat (4) @(negedge clk);
            check(pred_valid && pred_pix == p0 && !pred_last, "R8", "stalled beat held", pred_pix, p0);
            check(p0 == rpix(12, 0, 7), "R6", "stalled first pixel", p0, rpix(12, 0, 7));
            check(!req_ready, "R9", "ready during stall", req_ready, 0);
        end
        recv_block(1, 12, "R6");
        // Partial reconstruction keeps the request side closed (R9)
        send_recon(14, 62);
        check(!req_ready, "R9", "ready before pixel 7,7", req_ready, 0);
        @(negedge clk);
        recon_valid = 1'b1; recon_row = 3'd7; recon_col = 3'd7; recon_pix = rpix(14, 7, 7);
        @(negedge clk);
        recon_valid = 1'b0;
        check(req_ready, "R9", "ready after pixel 7,7", req_ready, 1);

        // Reset in the middle of a block clears the store (R1)
        send_req(1'b0, 1'b0, 2'd0, 1'b1);
        pred_ready = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!pred_valid, "R1", "valid in reset", pred_valid, 0);
        check(req_ready, "R1", "ready in reset", req_ready, 1);
        rst_n = 1'b1;
        send_req(1'b0, 1'b0, 2'd0, 1'b1);
        recv_block(1, -1, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule